// File: doc/BRIEF.md
# CTA Completion Tracker

This block sits on a shader core and follows the life of every thread block (CTA) resident there. A launch pulse names a free slot and the number of threads placed in it. Each exiting thread sends a pulse tagged with the slot recorded for its warp. The block keeps one live-thread counter per slot and one count of resident CTAs. When a slot drains, it pulses that slot's free line, which also tells the barrier logic to let go of the slot's barrier.

When the last resident CTA drains, the core pulses empty. That pulse is also the request to lower the kernel's running-core count, which lives outside this block. At the same moment the core drops its kernel binding. If the dispatcher reports that no CTAs are left to issue, and the running-core count supplied from outside shows no core except this one, the core also pulses kernel done.

Top module: `cta_retire_tracker`

## Requirements
- R1: While rst_ni is low, every slot count and the active count are zero, and every output is low or zero. This includes kernel_bound_o.
- R2: A launch loads slot launch_slot_i with launch_threads_i and raises active_cnt_o by one. Both take effect on the next clock edge. A launch may only target a slot whose count is zero, with a thread count of at least one.
- R3: An exit pulse lowers the count of slot exit_slot_i by one. When an exit takes a count from one to zero, bit k of slot_free_o is high for exactly one cycle, where k is the slot number. That cycle is the one after the exit, and active_cnt_o falls by one in the same cycle.
- R4: An exit aimed at a slot whose count is already zero makes exit_err_o high for one cycle after the exit. It changes no count and frees nothing.
- R5: A launch and an exit to different slots in the same cycle both take effect. active_cnt_o changes by the net amount.
- R6: When active_cnt_o reaches zero because a slot drained, core_empty_o pulses for one cycle. That is the cycle in which the count reads zero, and kernel_bound_o is low from that cycle on.
- R7: kernel_done_o pulses together with core_empty_o only if two conditions held in the exit cycle: no_more_ctas_i was high, and running_cores_i was at most 1. It never pulses at any other time.
- R8: kernel_bind_i sets kernel_bound_o from the next cycle on. If a bind and a core-emptying exit fall in the same cycle, the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| launch_valid_i | input | 1 | A CTA is placed in a slot this cycle |
| launch_slot_i | input | SLOT_W | Slot receiving the CTA |
| launch_threads_i | input | THREAD_W | Thread count of the launched CTA |
| exit_valid_i | input | 1 | One thread exits this cycle |
| exit_slot_i | input | SLOT_W | Slot recorded for the exiting thread's warp |
| kernel_bind_i | input | 1 | A kernel is assigned to this core |
| no_more_ctas_i | input | 1 | The kernel has no CTAs left to dispatch |
| running_cores_i | input | RUN_W | Cores currently running the kernel, this one included |
| slot_free_o | output | NUM_SLOTS | One-hot pulse: slot drained, release its barrier |
| active_cnt_o | output | ACT_W | Resident CTAs on this core |
| core_empty_o | output | 1 | Pulse: last CTA left; lower the kernel running count |
| kernel_done_o | output | 1 | Pulse: the whole kernel is finished |
| kernel_bound_o | output | 1 | A kernel is assigned to this core |
| exit_err_o | output | 1 | Pulse: exit arrived for a slot with no live threads |

## Verification
Two events can land in the same cycle: a launch into one slot and the exit that drains a different slot. Only the net change in the active count may show. The bench brings this about deliberately, and its random stimulus also gives each cycle a high chance of both events. A bench model tracks every slot count. Each cycle it compares the active count, the free vector and the empty pulse against that model. This shows whether a simultaneous launch masks a core-empty event or lets it through wrongly.

// File: rtl/cta_trk_pkg.sv
package cta_trk_pkg;
  function automatic int unsigned idx_width(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/cta_slot_counter.sv
module cta_slot_counter #(
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             retire_o,
  output logic             underflow_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (load_i)                   cnt_q <= load_val_i;
    else if (dec_i && cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o       = cnt_q;
  assign retire_o    = dec_i && !load_i && (cnt_q == CNT_W'(1));
  assign underflow_o = dec_i && (cnt_q == '0);

  a_r2_load_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(load_val_i));
  a_r2_load_into_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> cnt_q == '0 && load_val_i != '0);
  a_r3_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !load_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
  a_r4_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (underflow_o && !load_i) |=> cnt_q == '0);
endmodule

// File: rtl/cta_active_counter.sv
module cta_active_counter #(
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned ACT_W     = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [ACT_W-1:0] cnt_o,
  output logic             drain_o
);
  logic [ACT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (inc_i && !dec_i) cnt_q <= cnt_q + 1'b1;
    else if (dec_i && !inc_i) cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o   = cnt_q;
  assign drain_o = dec_i && !inc_i && (cnt_q == ACT_W'(1));

  a_r5_net_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> cnt_q == ACT_W'($past(cnt_q) + ACT_W'($past(inc_i)) - ACT_W'($past(dec_i))));
  a_r2_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= ACT_W'(NUM_SLOTS));
  a_r3_no_dec_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |-> cnt_q != '0);
endmodule

// File: rtl/cta_retire_tracker.sv
module cta_retire_tracker
  import cta_trk_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned THREAD_W  = 11,
  parameter int unsigned RUN_W     = 8,
  localparam int unsigned SLOT_W   = idx_width(NUM_SLOTS),
  localparam int unsigned ACT_W    = $clog2(NUM_SLOTS + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 launch_valid_i,
  input  logic [SLOT_W-1:0]    launch_slot_i,
  input  logic [THREAD_W-1:0]  launch_threads_i,
  input  logic                 exit_valid_i,
  input  logic [SLOT_W-1:0]    exit_slot_i,
  input  logic                 kernel_bind_i,
  input  logic                 no_more_ctas_i,
  input  logic [RUN_W-1:0]     running_cores_i,
  output logic [NUM_SLOTS-1:0] slot_free_o,
  output logic [ACT_W-1:0]     active_cnt_o,
  output logic                 core_empty_o,
  output logic                 kernel_done_o,
  output logic                 kernel_bound_o,
  output logic                 exit_err_o
);
  logic [NUM_SLOTS-1:0] retire_vec, underflow_vec;
  logic                 drain;
  logic [NUM_SLOTS-1:0] free_q;
  logic                 empty_q, done_q, bound_q, err_q;

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    logic [THREAD_W-1:0] cnt_unused;
    cta_slot_counter #(.CNT_W(THREAD_W)) i_slot (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .load_i      (launch_valid_i && launch_slot_i == SLOT_W'(k)),
      .load_val_i  (launch_threads_i),
      .dec_i       (exit_valid_i && exit_slot_i == SLOT_W'(k)),
      .cnt_o       (cnt_unused),
      .retire_o    (retire_vec[k]),
      .underflow_o (underflow_vec[k])
    );
  end

  cta_active_counter #(.NUM_SLOTS(NUM_SLOTS), .ACT_W(ACT_W)) i_active (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .inc_i   (launch_valid_i),
    .dec_i   (|retire_vec),
    .cnt_o   (active_cnt_o),
    .drain_o (drain)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      free_q  <= '0;
      empty_q <= 1'b0;
      done_q  <= 1'b0;
      bound_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      free_q  <= retire_vec;
      err_q   <= |underflow_vec;
      empty_q <= drain;
      // only this core (or none) still counted as running
      done_q  <= drain && no_more_ctas_i && (running_cores_i <= RUN_W'(1));
      if (drain)              bound_q <= 1'b0;
      else if (kernel_bind_i) bound_q <= 1'b1;
    end
  end

  assign slot_free_o    = free_q;
  assign core_empty_o   = empty_q;
  assign kernel_done_o  = done_q;
  assign kernel_bound_o = bound_q;
  assign exit_err_o     = err_q;

  a_r3_free_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(slot_free_o));
  a_r5_distinct_slots: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (launch_valid_i && exit_valid_i) |-> launch_slot_i != exit_slot_i);
  a_r6_empty_means_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_empty_o |-> (active_cnt_o == '0) && !kernel_bound_o && (slot_free_o != '0));
  a_r7_done_with_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kernel_done_o |-> core_empty_o);
  a_r4_err_frees_nothing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exit_err_o |-> slot_free_o == '0);
  a_r8_bind_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kernel_bind_i && !drain) |=> kernel_bound_o);
endmodule

// File: tb/test_cta_retire_tracker.sv
module test_cta_retire_tracker;
  localparam int NS = 8;
  localparam int TW = 11;
  localparam int RW = 8;
  localparam int SW = 3;
  localparam int AW = 4;

  logic clk_i = 1'b0;
  logic rst_ni;
  logic launch_valid_i, exit_valid_i, kernel_bind_i, no_more_ctas_i;
  logic [SW-1:0] launch_slot_i, exit_slot_i;
  logic [TW-1:0] launch_threads_i;
  logic [RW-1:0] running_cores_i;
  logic [NS-1:0] slot_free_o;
  logic [AW-1:0] active_cnt_o;
  logic core_empty_o, kernel_done_o, kernel_bound_o, exit_err_o;

  always #2.5 clk_i = ~clk_i;

  cta_retire_tracker #(.NUM_SLOTS(NS), .THREAD_W(TW), .RUN_W(RW)) i_cta_retire_tracker (
    .clk_i, .rst_ni, .launch_valid_i, .launch_slot_i, .launch_threads_i,
    .exit_valid_i, .exit_slot_i, .kernel_bind_i, .no_more_ctas_i, .running_cores_i,
    .slot_free_o, .active_cnt_o, .core_empty_o, .kernel_done_o, .kernel_bound_o, .exit_err_o);

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  int cnt [NS];
  int act = 0;
  bit bound = 0;
  logic [NS-1:0] e_free;
  bit e_err, e_empty, e_done;

  task automatic chk(input bit ok, input string req, input longint a, input longint e);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, a, e);
    end
  endtask

  task automatic compare_all();
    chk(active_cnt_o == AW'(act), "R2/R5 active_cnt", active_cnt_o, act);
    chk(slot_free_o == e_free, "R3 slot_free", slot_free_o, e_free);
    chk(exit_err_o == e_err, "R4 exit_err", exit_err_o, e_err);
    chk(core_empty_o == e_empty, "R6 core_empty", core_empty_o, e_empty);
    chk(kernel_done_o == e_done, "R7 kernel_done", kernel_done_o, e_done);
    chk(kernel_bound_o == bound, "R8 kernel_bound", kernel_bound_o, bound);
  endtask

  // drive one cycle, advance the model, compare after the edge
  task automatic step(input bit lv, input int ls, input int lt, input bit ev, input int es,
                      input bit bd, input bit nm, input int run);
    int nxt;
    launch_valid_i = lv; launch_slot_i = SW'(ls); launch_threads_i = TW'(lt);
    exit_valid_i = ev; exit_slot_i = SW'(es); kernel_bind_i = bd;
    no_more_ctas_i = nm; running_cores_i = RW'(run);
    e_free = '0; e_err = 0; e_empty = 0; e_done = 0;
    if (ev) begin
      if (cnt[es] == 0) e_err = 1;
      else begin
        cnt[es]--;
        if (cnt[es] == 0) e_free[es] = 1'b1;
      end
    end
    if (lv) cnt[ls] = lt;
    nxt = act + int'(lv) - int'(e_free != '0);
    if (e_free != '0 && nxt == 0) begin
      e_empty = 1;
      e_done = nm && (run <= 1);
    end
    act = nxt;
    if (e_empty) bound = 0; else if (bd) bound = 1;
    @(negedge clk_i);
    compare_all();
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #1ms;
    if (!finished) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int unused;
    unused = $urandom(32'h5eed_c7a1);
    foreach (cnt[i]) cnt[i] = 0;
    rst_ni = 0;
    launch_valid_i = 0; launch_slot_i = '0; launch_threads_i = '0;
    exit_valid_i = 0; exit_slot_i = '0; kernel_bind_i = 0;
    no_more_ctas_i = 0; running_cores_i = '0;
    e_free = '0; e_err = 0; e_empty = 0; e_done = 0;
    repeat (3) @(negedge clk_i);
    compare_all(); // R1 reset state
    chk(kernel_bound_o == 1'b0, "R1 bound at reset", kernel_bound_o, 0);
    rst_ni = 1;

    // directed: bind, one CTA of two threads in slot 2, drain with done (R8 R2 R3 R6 R7)
    step(0, 0, 0, 0, 0, 1, 0, 0);
    step(1, 2, 2, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 2, 0, 0, 0);
    step(0, 0, 0, 1, 2, 0, 1, 1);
    // R4: exit to empty slot
    step(0, 0, 0, 1, 5, 0, 0, 0);
    // R5: launch slot 1 while slot 3 drains; no empty pulse expected
    step(1, 3, 1, 0, 0, 1, 0, 0);
    step(1, 1, 3, 1, 3, 0, 1, 1);
    // R7: empty with other cores running -> no done; R8 bind and empty together -> cleared
    step(0, 0, 0, 1, 1, 0, 1, 2);
    step(0, 0, 0, 1, 1, 0, 1, 2);
    step(0, 0, 0, 1, 1, 1, 1, 2);
    idle();

    // constrained random
    for (int cyc = 0; cyc < 4000; cyc++) begin
      bit lv, ev, bd, nm;
      int ls, lt, es, run, start;
      lv = 0; ev = 0; ls = 0; es = 0;
      lt = 1 + int'($urandom_range(0, 4));
      if ($urandom_range(0, 99) < 45) begin
        start = int'($urandom_range(0, NS - 1));
        for (int j = 0; j < NS; j++)
          if (!lv && cnt[(start + j) % NS] == 0) begin lv = 1; ls = (start + j) % NS; end
      end
      if ($urandom_range(0, 99) < 70) begin
        bit want_err;
        want_err = ($urandom_range(0, 99) < 8);
        start = int'($urandom_range(0, NS - 1));
        for (int j = 0; j < NS; j++) begin
          int s;
          s = (start + j) % NS;
          if (!ev && !(lv && s == ls) && ((cnt[s] == 0) == want_err)) begin ev = 1; es = s; end
        end
      end
      bd = ($urandom_range(0, 99) < 10);
      nm = $urandom_range(0, 1);
      run = int'($urandom_range(0, 3));
      step(lv, ls, lt, ev, es, bd, nm, run);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule